// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave Controller

This block is the slave side of a four-wire serial peripheral bus in front of a 512-byte array that accepts writes at bus speed. It watches the chip-select, serial clock, hold and data-in pins, which are registered once in the system clock domain. It takes the first byte of each select window as a command. Array commands carry the ninth address bit inside the command byte. A low address byte follows, then a stream of data bytes. The address pointer advances after every byte and wraps across the whole array.

Written bytes go to an internal register file the moment their last bit arrives, provided a separate protection unit grants the write in that cycle. Read bytes are fetched at the byte boundary and shifted out on the data-out pin, most significant bit first. The two write-enable commands and the status-register write are handed to the protection unit as one-cycle strobes, and that unit supplies the status byte. A hold input freezes the transfer at any bit position. The data-out pin has its own output enable so that it can be tri-stated at the pad.

Top module: `spimem_slave`

## Requirements
- R1: After reset, and while chip select is high, `so_oe` is 0 and every strobe output (`cmd_wren`, `cmd_wrdi`, `sr_wr_req`, `wr_req`, `mem_we`, `mem_re`) is 0.
- R2: The bus works in clock-idle-low and clock-idle-high modes. `si` is taken on each rising `sck`, and `so_out` changes only after a falling `sck`, most significant bit first. A pin value is seen at the first system clock edge after it is driven, and strobes are high during the following cycle.
- R3: The first byte after chip select falls is the command. 0x06 gives one `cmd_wren` pulse and 0x04 gives one `cmd_wrdi` pulse, both in the cycle after the 8th rising `sck` is sampled. At most one strobe is high in any cycle.
- R4: Command 0000_A011 (bit 3 = address bit 8) starts a read. The next byte gives address bits 7..0, and a `mem_re` pulse is issued at that byte boundary. The MSB of the read byte appears on the first falling `sck` after the last address bit. Further `si` bits have no effect.
- R5: Command 0000_A010 (bit 3 = address bit 8) starts a write, and the next byte gives address bits 7..0. Each later complete byte raises `wr_req` with `mem_addr` and `mem_wdata` for one cycle. The byte is stored only if `wr_grant` is 1 in that cycle, which is also the cycle where `mem_we` is high.
- R6: Each further data byte of a read or write uses the previous address plus one, and 0x1FF is followed by 0x000. There is no limit on the number of bytes.
- R7: Command 0x05 shifts out the `sr_rdata` byte. A fresh copy of `sr_rdata` is taken at every byte boundary for as long as clocks continue.
- R8: Command 0x01 makes the next complete byte raise `sr_wr_req` for one cycle with that byte on `mem_wdata`. Later bytes in the same window are ignored.
- R9: `so_oe` is 1 only during a read-data or status-out phase, while chip select is low and hold is high.
- R10: While `hold_n` is low, `so_oe` is 0, and `sck` edges and chip-select changes have no effect. The transfer continues from the same bit once `hold_n` returns high.
- R11: Chip select rising (with `hold_n` high) ends the command and drops any partly received byte. A byte whose 8th rising `sck` is sampled together with chip select high is also dropped. Only a new select window accepts a new command.
- R12: Any other command byte produces no strobe and leaves `so_oe` at 0 until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck | input | 1 | Serial bus clock |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Transfer pause, active low |
| si | input | 1 | Serial data in |
| so_out | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the data-out pad |
| cmd_wren | output | 1 | Pulse: set-write-enable command decoded |
| cmd_wrdi | output | 1 | Pulse: clear-write-enable command decoded |
| sr_wr_req | output | 1 | Pulse: status byte received, value on mem_wdata |
| sr_rdata | input | 8 | Status byte supplied by the protection unit |
| wr_req | output | 1 | Pulse: array write requested at mem_addr |
| wr_grant | input | 1 | Protection unit permits the requested write |
| mem_re | output | 1 | Array read strobe |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 9 | Array byte address for the current strobe |
| mem_wdata | output | 8 | Received byte for array or status write |

## Verification
Two events can arrive in the same sampled cycle: the rising `sck` that completes a data byte, and the rise of chip select that ends the window. The bench drives both pins high in the same half period during a write, then reads the location back. It expects the value from an earlier full write, with no `wr_req` pulse in between. A second collision puts a drop of `wr_grant` in the very cycle of a write request: the bench expects `wr_req` without `mem_we`, and the old byte is read back afterwards.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  localparam int BYTE_W = 8;

  // Whole-byte command codes
  localparam logic [BYTE_W-1:0] CMD_SET_WE  = 8'h06;
  localparam logic [BYTE_W-1:0] CMD_CLR_WE  = 8'h04;
  localparam logic [BYTE_W-1:0] CMD_STAT_RD = 8'h05;
  localparam logic [BYTE_W-1:0] CMD_STAT_WR = 8'h01;

  // Array commands: upper nibble zero, bit 3 = address MSB, bits 2..1 = 01,
  // bit 0 selects read (1) or write (0)
  localparam logic [1:0] CMD_ARR_TAG = 2'b01;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADR_RD,
    PH_ADR_WR,
    PH_RD_DATA,
    PH_WR_DATA,
    PH_ST_OUT,
    PH_ST_IN,
    PH_SKIP
  } phase_e;

endpackage

// File: rtl/spimem_frontend.sv
module spimem_frontend #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          hold_n,
  input  logic          si,
  output logic          rise_ev,
  output logic          fall_ev,
  output logic          idle,
  output logic          sel_active,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = $clog2(DW);

  logic          sck_r, sck_p, cs_r, hold_r, si_r;
  logic [CW-1:0] bcnt_q, bcnt_nx;
  logic [DW-1:0] rx_q, rx_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_r  <= 1'b0;
      sck_p  <= 1'b0;
      cs_r   <= 1'b1;
      hold_r <= 1'b1;
      si_r   <= 1'b0;
      bcnt_q <= '0;
      rx_q   <= '0;
    end else begin
      sck_r  <= sck;
      sck_p  <= sck_r;
      cs_r   <= cs_n;
      hold_r <= hold_n;
      si_r   <= si;
      bcnt_q <= bcnt_nx;
      rx_q   <= rx_nx;
    end
  end

  // Edges count only while selected and not paused
  assign sel_active = hold_r & ~cs_r;
  assign idle       = hold_r & cs_r;
  assign rise_ev    = sel_active & sck_r & ~sck_p;
  assign fall_ev    = sel_active & ~sck_r & sck_p;
  assign rx_byte    = {rx_q[DW-2:0], si_r};
  assign byte_done  = rise_ev && (bcnt_q == CW'(DW - 1));

  always_comb begin
    bcnt_nx = bcnt_q;
    rx_nx   = rx_q;
    if (idle) begin
      bcnt_nx = '0;
    end else if (rise_ev) begin
      rx_nx   = rx_byte;
      bcnt_nx = byte_done ? '0 : bcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spimem_txsh.sv
module spimem_txsh #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  output logic          so
);
  logic [DW-1:0] sh_q, sh_nx;
  logic          so_q, so_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      so_q <= 1'b0;
    end else begin
      sh_q <= sh_nx;
      so_q <= so_nx;
    end
  end

  always_comb begin
    sh_nx = sh_q;
    so_nx = so_q;
    if (clr) begin
      so_nx = 1'b0;
    end else if (load) begin
      sh_nx = load_val;
    end else if (shift) begin
      so_nx = sh_q[DW-1];
      sh_nx = {sh_q[DW-2:0], 1'b0};
    end
  end

  assign so = so_q;

endmodule

// File: rtl/spimem_regfile.sv
module spimem_regfile #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
  import spimem_pkg::*;
#(
  parameter int DW          = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          hold_n,
  input  logic          si,
  output logic          so_out,
  output logic          so_oe,
  output logic          cmd_wren,
  output logic          cmd_wrdi,
  output logic          sr_wr_req,
  input  logic [DW-1:0] sr_rdata,
  output logic          wr_req,
  input  logic          wr_grant,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW:0]   mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int AW = DW + 1;

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_pipe[SYNC_STAGES-1];

  logic          rise_ev, fall_ev, idle, sel_active, byte_done;
  logic [DW-1:0] rx_byte, rd_byte, tx_val;
  logic          tx_load, tx_shift, out_phase;

  spimem_frontend #(.DW(DW)) u_fe (
    .clk(clk), .rst_n(rst_i), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .idle(idle), .sel_active(sel_active),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  phase_e        st_q, st_nx;
  logic [AW-1:0] ptr_q, ptr_nx, acc_addr;
  logic          ahi_q, ahi_nx;
  logic          rd_stb;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= PH_CMD;
      ptr_q <= '0;
      ahi_q <= 1'b0;
    end else begin
      st_q  <= st_nx;
      ptr_q <= ptr_nx;
      ahi_q <= ahi_nx;
    end
  end

  always_comb begin
    st_nx     = st_q;
    ptr_nx    = ptr_q;
    ahi_nx    = ahi_q;
    acc_addr  = ptr_q;
    cmd_wren  = 1'b0;
    cmd_wrdi  = 1'b0;
    sr_wr_req = 1'b0;
    wr_req    = 1'b0;
    rd_stb    = 1'b0;
    tx_load   = 1'b0;
    tx_val    = sr_rdata;
    if (idle) begin
      st_nx = PH_CMD;
    end else if (byte_done) begin
      case (st_q)
        PH_CMD: begin
          if (rx_byte == CMD_SET_WE) begin
            cmd_wren = 1'b1;
            st_nx    = PH_SKIP;
          end else if (rx_byte == CMD_CLR_WE) begin
            cmd_wrdi = 1'b1;
            st_nx    = PH_SKIP;
          end else if (rx_byte == CMD_STAT_RD) begin
            tx_load = 1'b1;
            st_nx   = PH_ST_OUT;
          end else if (rx_byte == CMD_STAT_WR) begin
            st_nx = PH_ST_IN;
          end else if (rx_byte[DW-1:4] == '0 && rx_byte[2:1] == CMD_ARR_TAG) begin
            ahi_nx = rx_byte[3];
            st_nx  = rx_byte[0] ? PH_ADR_RD : PH_ADR_WR;
          end else begin
            st_nx = PH_SKIP;
          end
        end
        PH_ADR_RD: begin
          acc_addr = {ahi_q, rx_byte};
          rd_stb   = 1'b1;
          tx_load  = 1'b1;
          tx_val   = rd_byte;
          ptr_nx   = acc_addr + 1'b1;
          st_nx    = PH_RD_DATA;
        end
        PH_RD_DATA: begin
          rd_stb  = 1'b1;
          tx_load = 1'b1;
          tx_val  = rd_byte;
          ptr_nx  = ptr_q + 1'b1;
        end
        PH_ADR_WR: begin
          ptr_nx = {ahi_q, rx_byte};
          st_nx  = PH_WR_DATA;
        end
        PH_WR_DATA: begin
          wr_req = 1'b1;
          ptr_nx = ptr_q + 1'b1;
        end
        PH_ST_OUT: begin
          tx_load = 1'b1;
        end
        PH_ST_IN: begin
          sr_wr_req = 1'b1;
          st_nx     = PH_SKIP;
        end
        default: ;
      endcase
    end
  end

  assign out_phase = (st_q == PH_RD_DATA) || (st_q == PH_ST_OUT);
  assign tx_shift  = fall_ev & out_phase;
  assign so_oe     = sel_active & out_phase;
  assign mem_re    = rd_stb;
  assign mem_we    = wr_req & wr_grant;
  assign mem_addr  = acc_addr;
  assign mem_wdata = rx_byte;

  spimem_txsh #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_i), .clr(idle), .load(tx_load), .load_val(tx_val),
    .shift(tx_shift), .so(so_out)
  );

  spimem_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk(clk), .we(mem_we), .addr(acc_addr), .wdata(rx_byte), .rdata(rd_byte)
  );

endmodule

// File: rtl/spimem_checker.sv
module spimem_checker #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          hold_n,
  input logic          so_oe,
  input logic          cmd_wren,
  input logic          cmd_wrdi,
  input logic          sr_wr_req,
  input logic          wr_req,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr
);
  logic          seen_wr;
  logic [AW-1:0] last_wr;
  logic          any_stb;

  assign any_stb = cmd_wren | cmd_wrdi | sr_wr_req | wr_req | mem_re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr <= 1'b0;
      last_wr <= '0;
    end else if (cs_n) begin
      seen_wr <= 1'b0;
    end else if (wr_req) begin
      seen_wr <= 1'b1;
      last_wr <= mem_addr;
    end
  end

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren, cmd_wrdi, sr_wr_req, wr_req, mem_re}));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && seen_wr) |-> (mem_addr == last_wr + 1'b1));

  p_oe_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (!$past(cs_n) && $past(hold_n)));

  p_no_oe_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !so_oe);

  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hold_n) |-> (!any_stb && !so_oe));

  p_desel_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !any_stb);

endmodule

bind spimem_slave spimem_checker #(.AW(DW + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
  .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .sr_wr_req(sr_wr_req),
  .wr_req(wr_req), .mem_re(mem_re), .mem_addr(mem_addr)
);

// File: tb/sim_spimem_slave.sv
module sim_spimem_slave;
  localparam int HP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic [7:0] sr_rdata = 8'h00;
  logic       wr_grant = 1'b1;
  logic       so_out, so_oe, cmd_wren, cmd_wrdi, sr_wr_req, wr_req, mem_re, mem_we;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;

  always #10 clk = ~clk;

  spimem_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .so_out(so_out), .so_oe(so_oe), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .sr_wr_req(sr_wr_req), .sr_rdata(sr_rdata), .wr_req(wr_req), .wr_grant(wr_grant),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_st;          // 0 cmd,1 adr rd,2 adr wr,3 rd data,4 wr data,5 st out,6 st in,7 skip
  int  m_cnt, m_ptr, m_hi;
  bit  m_prev, m_so;
  logic [7:0] m_rx;
  bit  txq[$];
  logic [7:0] mem[int];
  bit  e_oe, e_so, e_wren, e_wrdi, e_srw, e_wrq, e_we, e_re;
  int  e_addr, e_wd;

  task automatic m_load(input logic [7:0] v);
    txq.delete();
    for (int i = 7; i >= 0; i--) txq.push_back(v[i]);
  endtask

  task automatic m_read(input int a);
    e_re = 1; e_addr = a;
    m_load(mem.exists(a) ? mem[a] : 8'h00);
  endtask

  task automatic m_byte(input logic [7:0] b);
    case (m_st)
      0: begin
        if (b == 8'h06) begin e_wren = 1; m_st = 7; end
        else if (b == 8'h04) begin e_wrdi = 1; m_st = 7; end
        else if (b == 8'h05) begin m_load(sr_rdata); m_st = 5; end
        else if (b == 8'h01) m_st = 6;
        else if (b[7:4] == 4'h0 && b[2:1] == 2'b01) begin
          m_hi = b[3]; m_st = b[0] ? 1 : 2;
        end else m_st = 7;
      end
      1: begin m_read(m_hi * 256 + b); m_ptr = (e_addr + 1) % 512; m_st = 3; end
      3: begin m_read(m_ptr); m_ptr = (m_ptr + 1) % 512; end
      2: begin m_ptr = m_hi * 256 + b; m_st = 4; end
      4: begin
        e_wrq = 1; e_addr = m_ptr; e_wd = b; e_we = wr_grant;
        if (wr_grant) mem[m_ptr] = b;
        m_ptr = (m_ptr + 1) % 512;
      end
      5: m_load(sr_rdata);
      6: begin e_srw = 1; e_wd = b; m_st = 7; end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    bit run, rise, fall;
    e_wren = 0; e_wrdi = 0; e_srw = 0; e_wrq = 0; e_we = 0; e_re = 0;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_prev = 0; m_so = 0; m_rx = 0; e_oe = 0; e_so = 0;
    end else begin
      run  = hold_n && !cs_n;
      rise = run && sck && !m_prev;
      fall = run && !sck && m_prev;
      e_oe = run && (m_st == 3 || m_st == 5);
      e_so = m_so;
      if (hold_n && cs_n) begin
        m_st = 0; m_cnt = 0; m_so = 0;
      end else if (rise) begin
        m_rx = {m_rx[6:0], si};
        m_cnt++;
        if (m_cnt == 8) begin m_cnt = 0; m_byte(m_rx); end
      end else if (fall && (m_st == 3 || m_st == 5)) begin
        m_so = (txq.size() > 0) ? txq.pop_front() : 1'b0;
      end
      m_prev = sck;
    end
  end

  // ---------------- per-cycle comparison and pulse counters ----------------
  int n_wren = 0, n_wrdi = 0, n_srw = 0, n_wrq = 0, n_we = 0;
  logic [7:0] last_srw = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 so_oe", so_oe, e_oe);
      if (e_oe) chk("R2 so_out", so_out, e_so);
      chk("R3 cmd_wren", cmd_wren, e_wren);
      chk("R3 cmd_wrdi", cmd_wrdi, e_wrdi);
      chk("R8 sr_wr_req", sr_wr_req, e_srw);
      chk("R5 wr_req", wr_req, e_wrq);
      chk("R5 mem_we", mem_we, e_we);
      chk("R4 mem_re", mem_re, e_re);
      if (e_re || e_wrq) chk("R6 mem_addr", mem_addr, e_addr);
      if (e_wrq || e_srw) chk("R8 mem_wdata", mem_wdata, e_wd);
      if (cmd_wren) n_wren++;
      if (cmd_wrdi) n_wrdi++;
      if (sr_wr_req) begin n_srw++; last_srw = mem_wdata; end
      if (wr_req) n_wrq++;
      if (mem_we) n_we++;
    end
  end

  // ---------------- bus master tasks ----------------
  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic open_win(input bit m3);
    @(negedge clk);
    sck = m3; wait_hp();
    cs_n = 1'b0; wait_hp();
  endtask

  task automatic close_win(input bit m3);
    sck = m3; wait_hp();
    cs_n = 1'b1; wait_hp();
    sck = 1'b0; wait_hp();
  endtask

  task automatic send_bit(input bit b, output bit r);
    sck = 1'b0; si = b; wait_hp();
    r = so_out;
    sck = 1'b1; wait_hp();
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      bit t;
      send_bit(b[i], t);
      r[i] = t;
    end
  endtask

  task automatic put(input logic [7:0] b);
    logic [7:0] d;
    xfer(b, d);
  endtask

  logic [7:0] rd;

  initial begin
    int w0, w1;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 so_oe in reset", so_oe, 0);
    chk("R1 strobes in reset", {cmd_wren, cmd_wrdi, sr_wr_req, wr_req, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 so_oe after reset", so_oe, 0);

    // R3: set-write-enable in idle-low mode, clear in idle-high mode (R2)
    open_win(0); put(8'h06); close_win(0);
    chk("R3 one cmd_wren", n_wren, 1);
    open_win(1); put(8'h04); close_win(1);
    chk("R3 R2 one cmd_wrdi", n_wrdi, 1);

    // R11: second command in the same window is ignored
    open_win(0); put(8'h06); put(8'h04); close_win(0);
    chk("R11 second command ignored (wren)", n_wren, 2);
    chk("R11 second command ignored (wrdi)", n_wrdi, 1);

    // R5 R6: write across the top of the array
    open_win(0); put(8'h0A); put(8'hFE);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44); close_win(0);
    chk("R5 four write requests", n_wrq, 4);
    chk("R5 four stores", n_we, 4);

    // R4 R6 R2: read back in idle-high mode, wrapping 1FF -> 000
    open_win(1); put(8'h0B); put(8'hFE);
    xfer(8'hFF, rd); chk("R4 read 1FE", rd, 8'h11);
    xfer(8'h00, rd); chk("R6 read 1FF", rd, 8'h22);
    xfer(8'hA5, rd); chk("R6 read 000 after wrap", rd, 8'h33);
    xfer(8'h5A, rd); chk("R4 read 001 si ignored", rd, 8'h44);
    close_win(1);
    chk("R9 so_oe off after read", so_oe, 0);

    // R5: denied write leaves the old byte
    open_win(0); put(8'h02); put(8'h10); put(8'h77); close_win(0);
    w0 = n_we; w1 = n_wrq;
    @(negedge clk); wr_grant = 1'b0;
    open_win(0); put(8'h02); put(8'h10); put(8'h55); close_win(0);
    wr_grant = 1'b1;
    chk("R5 request without grant", n_wrq - w1, 1);
    chk("R5 no store without grant", n_we - w0, 0);
    open_win(0); put(8'h03); put(8'h10); xfer(8'h00, rd); close_win(0);
    chk("R5 denied write kept old byte", rd, 8'h77);

    // R7: status out, reloaded each byte
    @(negedge clk); sr_rdata = 8'h8C;
    open_win(0); put(8'h05);
    sr_rdata = 8'h3C;
    xfer(8'h00, rd); chk("R7 first status byte", rd, 8'h8C);
    xfer(8'h00, rd); chk("R7 reloaded status byte", rd, 8'h3C);
    close_win(0);

    // R8: status write request
    open_win(1); put(8'h01); put(8'h0C); put(8'hEE); close_win(1);
    chk("R8 one status write", n_srw, 1);
    chk("R8 status byte", last_srw, 8'h0C);

    // R10: hold in the middle of a read data byte
    open_win(0); put(8'h03); put(8'h00);
    for (int i = 7; i >= 0; i--) begin
      bit t;
      send_bit(1'b0, t);
      rd[i] = t;
      if (i == 5) begin
        sck = 1'b0; wait_hp();
        hold_n = 1'b0; wait_hp();
        chk("R10 so_oe off in hold", so_oe, 0);
        sck = 1'b1; wait_hp(); sck = 1'b0; wait_hp();
        cs_n = 1'b1; wait_hp(); cs_n = 1'b0; wait_hp();
        hold_n = 1'b1; wait_hp();
      end
    end
    close_win(0);
    chk("R10 byte intact across hold", rd, 8'h33);

    // R11: partial byte and byte colliding with chip select rise
    open_win(0); put(8'h02); put(8'h20); put(8'h99); close_win(0);
    w1 = n_wrq;
    open_win(0); put(8'h02); put(8'h20);
    for (int i = 7; i >= 3; i--) begin bit t; send_bit(1'b1, t); end
    close_win(0);
    open_win(0); put(8'h02); put(8'h20);
    for (int i = 7; i >= 1; i--) begin bit t; send_bit(1'b0, t); end
    sck = 1'b0; si = 1'b1; wait_hp();
    sck = 1'b1; cs_n = 1'b1; wait_hp();
    sck = 1'b0; wait_hp();
    chk("R11 no write from cut bytes", n_wrq - w1, 0);
    open_win(0); put(8'h03); put(8'h20); xfer(8'h00, rd); close_win(0);
    chk("R11 location unchanged", rd, 8'h99);

    // R12: unknown command is inert
    w0 = n_wren + n_wrdi + n_srw + n_wrq;
    open_win(0); put(8'hA3); put(8'h06); put(8'h01);
    chk("R12 no so_oe", so_oe, 0);
    close_win(0);
    chk("R12 no strobes", n_wren + n_wrdi + n_srw + n_wrq - w0, 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule